// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port

This block gives software control of sixteen general-purpose pins through a small register bus with a write strobe, a read strobe, an address and data words in both directions. Each pin can be an output or an input. Output values live in one data register. That register can also be reached through two alias addresses. One alias only sets the bits written as one, and the other only clears them, so any group of pins can change in a single write without a read-modify-write sequence.

Pad inputs pass through a two-stage synchronizer. A pin that is both driven and enabled for input sees its own output value instead of the pad level, which lets software check the output path without external wiring. Each pin can raise an interrupt in one of three ways: while its level is high, on a rising edge, or on either edge. Edge events are held in sticky status bits that software clears by writing ones. The masked status bits are combined into one registered interrupt request.

Top module: `pio_port16`

Register map (4-bit address; reads return data one cycle after the read strobe):
0 direction (1 = output), 1 output data, 2 output set alias (write ones to set; reads the output data), 3 output clear alias (write ones to clear; reads the output data), 4 input enable, 5 pin value (read-only), 6 interrupt mask, 7 sense select (0 = level, 1 = edge), 8 edge mode (0 = rising only, 1 = both edges), 9 interrupt status (write ones to clear edge events).

## Requirements
- R1: `pin_oe[i]` equals bit i of the direction register at address 0, where 1 means the pin is an output.
- R2: A write to address 2 sets each output data bit that is written as one. Bits written as zero keep their value.
- R3: A write to address 3 clears each output data bit that is written as one. Bits written as zero keep their value.
- R4: `pin_out` carries the output data register, and a read of address 1 returns it.
- R5: A read of address 5 returns the pad level, delayed by the two-stage synchronizer, for pins whose input enable bit (address 4) is 1, and returns 0 for the other pins.
- R6: For a pin whose direction bit and input enable bit are both 1, address 5 returns that pin's output data bit and ignores the pad.
- R7: A pin with sense bit 0 shows its current address 5 value in the status register at address 9. While that bit and its mask are both 1, `irq` is high.
- R8: A pin with sense bit 1 and edge mode bit 0 latches a status bit on a rising edge of its address 5 value. A falling edge latches nothing.
- R9: A pin with sense bit 1 and edge mode bit 1 latches a status bit on both rising and falling edges.
- R10: Writing one to a bit of address 9 clears that latched edge bit. Bits written as zero leave their latched bits set.
- R11: `irq` is the registered OR of the status bits ANDed with the mask bits at address 6. A masked pin never raises it.
- R12: After reset every register is zero, so `pin_oe`, `pin_out` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes take effect at the clock edge that samples the strobe. Read data is due at the next edge. A pad change reaches address 5 two edges after it is applied. A level interrupt appears one edge later, that is three edges after the pad change. An edge interrupt appears four edges after the pad change, because the edge bit is latched one edge before the request register. The bench drives inputs on falling edges and samples outputs on falling edges. It checks `irq` low at the edge before its due edge and high at its due edge. Read results go into a queue, and a monitor compares each one on the falling edge after the sampling edge.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int unsigned PIO_AW = 4;

    typedef enum logic [PIO_AW-1:0] {
        A_DIR    = 4'd0,
        A_OUT    = 4'd1,
        A_SET    = 4'd2,
        A_CLR    = 4'd3,
        A_INEN   = 4'd4,
        A_PIN    = 4'd5,
        A_MASK   = 4'd6,
        A_SENSE  = 4'd7,
        A_BOTH   = 4'd8,
        A_STATUS = 4'd9
    } pio_addr_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = d;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [PIO_AW-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      dout,
    output logic [W-1:0]      inen,
    output logic [W-1:0]      mask,
    output logic [W-1:0]      sense,
    output logic [W-1:0]      both,
    output logic [W-1:0]      stat_clr
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dout;
        logic [W-1:0] inen;
        logic [W-1:0] mask;
        logic [W-1:0] sense;
        logic [W-1:0] both;
    } regs_t;

    regs_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        stat_clr = '0;
        if (wr) begin
            unique case (addr)
                A_DIR:    st_d.dir   = wdata;
                A_OUT:    st_d.dout  = wdata;
                A_SET:    st_d.dout  = st_q.dout | wdata;
                A_CLR:    st_d.dout  = st_q.dout & ~wdata;
                A_INEN:   st_d.inen  = wdata;
                A_MASK:   st_d.mask  = wdata;
                A_SENSE:  st_d.sense = wdata;
                A_BOTH:   st_d.both  = wdata;
                A_STATUS: stat_clr   = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir   = st_q.dir;
    assign dout  = st_q.dout;
    assign inen  = st_q.inen;
    assign mask  = st_q.mask;
    assign sense = st_q.sense;
    assign both  = st_q.both;

    AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_SET) |=> (dout == ($past(dout) | $past(wdata)))); // R2
    AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CLR) |=> (dout == ($past(dout) & ~$past(wdata)))); // R3
    AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == A_DIR) |=> $stable(dir)); // R1
endmodule

// File: rtl/pio_event.sv
module pio_event #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_val,
    input  logic [W-1:0] sense,
    input  logic [W-1:0] both,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] clr,
    output logic [W-1:0] status,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] sticky;
        logic [W-1:0] prev;
        logic         irq;
    } ev_t;

    ev_t st_q, st_d;
    logic [W-1:0] rise, any_edge, hit;

    always_comb begin
        rise     = pin_val & ~st_q.prev;
        any_edge = pin_val ^ st_q.prev;
        hit      = sense & ((both & any_edge) | (~both & rise));
        status   = (sense & st_q.sticky) | (~sense & pin_val);

        st_d        = st_q;
        st_d.sticky = (st_q.sticky & ~clr) | hit;
        st_d.prev   = pin_val;
        st_d.irq    = |(status & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.sticky & $past(st_q.sticky & ~clr)) == $past(st_q.sticky & ~clr))); // R10
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(mask) != '0)); // R11
    AST_NO_FALL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr == '0) && (sense == '1) && (both == '0) && ((pin_val & ~st_q.prev) == '0))
        |=> (st_q.sticky == $past(st_q.sticky))); // R8
endmodule

// File: rtl/pio_port16.sv
module pio_port16
    import pio_pkg::*;
#(
    parameter int unsigned NPINS     = 16,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [PIO_AW-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] dir, dout, inen, mask, sense, both, stat_clr;
    logic [NPINS-1:0] pad_sync, loop_sel, pin_val, status;
    logic [NPINS-1:0] rdata_q, rdata_d, rmux;

    pio_sync #(.W(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pad_sync)
    );

    pio_regs #(.W(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .dir(dir), .dout(dout), .inen(inen), .mask(mask), .sense(sense),
        .both(both), .stat_clr(stat_clr)
    );

    always_comb begin
        loop_sel = dir & inen;
        pin_val  = inen & ((loop_sel & dout) | (~loop_sel & pad_sync));
    end

    pio_event #(.W(NPINS)) u_event (
        .clk(clk), .rst_n(rst_n), .pin_val(pin_val), .sense(sense), .both(both),
        .mask(mask), .clr(stat_clr), .status(status), .irq(irq)
    );

    always_comb begin
        unique case (bus_addr)
            A_DIR:                rmux = dir;
            A_OUT, A_SET, A_CLR:  rmux = dout;
            A_INEN:               rmux = inen;
            A_PIN:                rmux = pin_val;
            A_MASK:               rmux = mask;
            A_SENSE:              rmux = sense;
            A_BOTH:               rmux = both;
            A_STATUS:             rmux = status;
            default:              rmux = '0;
        endcase
        rdata_d = bus_rd ? rmux : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = dout;
    assign pin_oe    = dir;

    AST_LOOP_IGNORES_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_PIN) |=> ((bus_rdata & $past(pin_oe & inen)) == ($past(pin_out & pin_oe & inen)))); // R6
    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_PIN) |=> ((bus_rdata & ~$past(inen)) == '0)); // R5
endmodule

// File: tb/pio_port16_tb_top.sv
module pio_port16_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [NP-1:0] exp_q [$];
    string         tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_port16 dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [NP-1:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_pad(input logic [NP-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares each read result on the falling edge after it is sampled
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (exp_q.size() != 0) begin
                    automatic logic [NP-1:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R12 reset state
        check("R12 pin_oe", pin_oe, '0);
        check("R12 pin_out", pin_out, '0);
        check("R12 irq", {15'd0, irq}, '0);
        rd(4'd0, 16'h0000, "R12 dir reset");
        rd(4'd9, 16'h0000, "R12 status reset");

        // R1 direction
        wr(4'd0, 16'h00FF);
        check("R1 pin_oe", pin_oe, 16'h00FF);

        // R4 output data
        wr(4'd1, 16'h1234);
        check("R4 pin_out", pin_out, 16'h1234);
        rd(4'd1, 16'h1234, "R4 read out");

        // R2 / R3 aliases
        wr(4'd2, 16'h0F00);
        check("R2 set alias", pin_out, 16'h1F34);
        rd(4'd2, 16'h1F34, "R2 alias reads data");
        wr(4'd3, 16'h0034);
        check("R3 clear alias", pin_out, 16'h1F00);
        wr(4'd3, 16'h0000);
        check("R3 zero clear", pin_out, 16'h1F00);

        // R5 synchronized, gated pin value
        wr(4'd4, 16'hFF00);
        set_pad(16'hA5C3);
        idle(3);
        rd(4'd5, 16'hA500, "R5 gated pin read");

        // R6 loopback: oe&inen = 0x000F, out low nibble 0, pad low nibble 3
        wr(4'd4, 16'h0F0F);
        rd(4'd5, 16'h0500, "R6 loopback zero");
        wr(4'd2, 16'h0005);
        rd(4'd5, 16'h0505, "R6 loopback set");
        set_pad(16'hA5CA);
        idle(3);
        rd(4'd5, 16'h0505, "R6 pad ignored");

        // prepare sensing
        wr(4'd0, 16'h0000);
        wr(4'd4, 16'hFFFF);
        set_pad(16'h0000);
        idle(4);
        wr(4'd9, 16'hFFFF);

        // R7 level
        wr(4'd6, 16'h0001);
        set_pad(16'h0001);
        idle(2);
        check("R7 irq early", {15'd0, irq}, 16'h0);
        idle(1);
        check("R7 irq due", {15'd0, irq}, 16'h1);
        rd(4'd9, 16'h0001, "R7 level status");
        set_pad(16'h0000);
        idle(4);
        check("R7 irq drops", {15'd0, irq}, 16'h0);
        rd(4'd9, 16'h0000, "R7 status follows");

        // R8 rising
        wr(4'd6, 16'h0002);
        wr(4'd7, 16'h0002);
        wr(4'd8, 16'h0000);
        set_pad(16'h0002);
        idle(3);
        check("R8 irq early", {15'd0, irq}, 16'h0);
        idle(1);
        check("R8 irq due", {15'd0, irq}, 16'h1);
        rd(4'd9, 16'h0002, "R8 rise latched");
        wr(4'd9, 16'h0002);
        idle(1);
        check("R10 irq after clear", {15'd0, irq}, 16'h0);
        set_pad(16'h0000);
        idle(4);
        rd(4'd9, 16'h0000, "R8 fall ignored");
        check("R8 irq on fall", {15'd0, irq}, 16'h0);

        // R9 both edges
        wr(4'd6, 16'h0004);
        wr(4'd7, 16'h0004);
        wr(4'd8, 16'h0004);
        set_pad(16'h0004);
        idle(4);
        rd(4'd9, 16'h0004, "R9 rise latched");
        wr(4'd9, 16'h0004);
        set_pad(16'h0000);
        idle(4);
        rd(4'd9, 16'h0004, "R9 fall latched");

        // R10 write-one-to-clear
        wr(4'd9, 16'h0000);
        rd(4'd9, 16'h0004, "R10 zero write keeps");
        wr(4'd9, 16'h0004);
        rd(4'd9, 16'h0000, "R10 one write clears");

        // R11 masking
        wr(4'd6, 16'h0000);
        wr(4'd7, 16'h0006);
        set_pad(16'h0002);
        idle(5);
        rd(4'd9, 16'h0002, "R11 status while masked");
        check("R11 masked irq", {15'd0, irq}, 16'h0);
        wr(4'd6, 16'h0002);
        idle(1);
        check("R11 unmasked irq", {15'd0, irq}, 16'h1);

        idle(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule